// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits between the two access ports of a shared dual-port memory and resolves collisions. Each port, left and right, presents an enable, a write strobe and an address, all sampled on one common clock. When both ports are enabled on the same address, the arbiter grants the location to the port that got there first and raises a busy flag toward the other one. The busy port's write strobe is masked before it reaches the array. A read issued while busy is passed through but marked as possibly stale.

A mode input selects between master and slave operation. In master mode busy is decided here and driven out, so that other instances can be ganged to it for a wider word. In slave mode the arbitration here is bypassed. Busy is then imported from the master's busy outputs, and a write is released only after the imported busy has been quiet long enough to be trusted.

Top module: `port_contention_arbiter`

## Requirements
- R1: Contention exists only when both enables are high and the two addresses are equal. In any other case both busy flags stay low, and in master mode an enabled write passes unchanged.
- R2: If one port was already enabled on an address in the previous cycle and the other port enables onto that same address, the port that was there first wins. Busy rises only on the other port, in the same cycle that the match appears.
- R3: If a match is created by one port changing its address onto the address the other port already held in the previous cycle, the holding port wins and the moving port is busy.
- R4: Busy falls in the same cycle that the addresses diverge or either enable drops.
- R5: When both ports arrive on the same address in the same cycle, exactly one port is granted and the other is busy. The parameter LEFT_WINS chooses which one.
- R6: Once a match is resolved, the winner keeps the location for as long as the match persists. Toggling the loser's write strobe does not move the busy flag.
- R7: A write output is high only when that port is enabled, is writing and is not busy. An enabled read on a busy port raises that port's stale flag. A port that is not busy shows no stale flag.
- R8: With master_mode high (1), the busy outputs are the locally computed result and the busy inputs are ignored. With master_mode low (0), each busy output follows that port's busy input, and local arbitration has no effect.
- R9: In slave mode, a new access blocks the port's write output in the cycle it appears and for the SETTLE_CYCLES cycles that follow. A new access is an enable change, or an address change while enabled. The write passes in the next cycle if the busy input stays low.
- R10: In slave mode, a high busy input blocks the write output at once. After the busy input falls, the write stays blocked for SETTLE_CYCLES more cycles.
- R11: While reset is held with idle ports, every busy, write and stale output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = compute busy locally, 0 = import busy |
| l_en | input | 1 | Left port access enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port access enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in | input | 1 | Imported left busy (slave mode) |
| r_busy_in | input | 1 | Imported right busy (slave mode) |
| l_busy | output | 1 | Left port lost the location |
| r_busy | output | 1 | Right port lost the location |
| l_we_out | output | 1 | Gated left write strobe to the array |
| r_we_out | output | 1 | Gated right write strobe to the array |
| l_stale | output | 1 | Left read issued while busy |
| r_stale | output | 1 | Right read issued while busy |

## Verification
Match detection is tried with enabled ports on different addresses, and with one port enabled and the other disabled on the same address. These show that address equality alone does not create busy. Arrival order is tried three ways: a late enable, a late address move and a same-cycle arrival. The first two tell the two winner rules apart from the fixed tie-break, and the bench checks only that the tie yields exactly one grant. Slave runs hold the address stable and pulse the busy input, which separates the settle window of a new access from the shorter one that follows a busy release.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int unsigned NPORTS = 2;
endpackage

// File: rtl/port_history.sv
// One-cycle history of a port: whether it already sat on its current
// address, and whether its access changed at this edge.
module port_history #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held,
  output logic              changed
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  assign held    = en & prev_en & (addr == prev_addr);
  assign changed = (en != prev_en) | (en & (addr != prev_addr));
endmodule

// File: rtl/contention_arbiter.sv
// Match detection, first-arrival resolution and ownership hold.
module contention_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter bit          LEFT_WINS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        en,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [1:0]        held,
  output logic [1:0]        busy
);
  logic   match;
  owner_e owner_q, fresh_pick, winner;

  assign match = en[0] & en[1] & (addr_l == addr_r);

  always_comb begin
    if (held[0] && !held[1])      fresh_pick = OWN_LEFT;
    else if (held[1] && !held[0]) fresh_pick = OWN_RIGHT;
    else                          fresh_pick = LEFT_WINS ? OWN_LEFT : OWN_RIGHT;

    if (!match)                   winner = OWN_NONE;
    else if (owner_q != OWN_NONE) winner = owner_q;
    else                          winner = fresh_pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= winner;
  end

  assign busy[0] = (winner == OWN_RIGHT);
  assign busy[1] = (winner == OWN_LEFT);

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[0] || !en[1]) |-> (busy == 2'b00));

  p_first_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !$past(match) && held[0] && !held[1]) |-> (busy == 2'b10));

  p_owner_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match && (|busy)) |=> (!match || (busy == $past(busy))));
endmodule

// File: rtl/slave_gate.sv
// Settle window for an imported busy: a write is released only after
// the access and the busy input have been quiet for SETTLE cycles.
module slave_gate #(
  parameter int unsigned SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_in,
  input  logic changed,
  output logic ok
);
  localparam int unsigned CW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [CW-1:0] CMAX = CW'(SETTLE);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (changed | busy_in) cnt <= '0;
    else if (cnt != CMAX)       cnt <= cnt + CW'(1);
  end

  assign ok = (cnt == CMAX) & ~changed & ~busy_in;

  p_block_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |-> !ok);

  p_settled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> $past(!busy_in));
endmodule

// File: rtl/port_contention_arbiter.sv
module port_contention_arbiter
  import dpa_pkg::*;
#(
  parameter int unsigned ADDR_W        = 13,
  parameter bit          LEFT_WINS     = 1'b1,
  parameter int unsigned SETTLE_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in,
  input  logic              r_busy_in,
  output logic              l_busy,
  output logic              r_busy,
  output logic              l_we_out,
  output logic              r_we_out,
  output logic              l_stale,
  output logic              r_stale
);
  logic [NPORTS-1:0] en_v, we_v, busy_in_v;
  logic [NPORTS-1:0] held_v, changed_v, ok_v;
  logic [NPORTS-1:0] busy_loc, busy_v, we_out_v, stale_v;
  logic [ADDR_W-1:0] addr_v [NPORTS];

  assign en_v      = {r_en, l_en};
  assign we_v      = {r_we, l_we};
  assign busy_in_v = {r_busy_in, l_busy_in};
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;

  contention_arbiter #(
    .ADDR_W    (ADDR_W),
    .LEFT_WINS (LEFT_WINS)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_v),
    .addr_l (l_addr),
    .addr_r (r_addr),
    .held   (held_v),
    .busy   (busy_loc)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    port_history #(.ADDR_W(ADDR_W)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .held    (held_v[p]),
      .changed (changed_v[p])
    );

    slave_gate #(.SETTLE(SETTLE_CYCLES)) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy_in (busy_in_v[p]),
      .changed (changed_v[p]),
      .ok      (ok_v[p])
    );

    always_comb begin
      busy_v[p]   = master_mode ? busy_loc[p] : busy_in_v[p];
      we_out_v[p] = en_v[p] & we_v[p] & (master_mode ? ~busy_loc[p] : ok_v[p]);
      stale_v[p]  = en_v[p] & ~we_v[p] & busy_v[p];
    end
  end

  assign l_busy   = busy_v[0];
  assign r_busy   = busy_v[1];
  assign l_we_out = we_out_v[0];
  assign r_we_out = we_out_v[1];
  assign l_stale  = stale_v[0];
  assign r_stale  = stale_v[1];

  p_gated_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
    l_we_out |-> (l_en && l_we && !l_busy));

  p_gated_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
    r_we_out |-> (r_en && r_we && !r_busy));
endmodule

// File: tb/port_contention_arbiter_tb.sv
module port_contention_arbiter_tb;
  localparam int unsigned AW     = 13;
  localparam int unsigned SETTLE = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, master_mode;
  logic          l_en, l_we, r_en, r_we, l_busy_in, r_busy_in;
  logic [AW-1:0] l_addr, r_addr;
  logic          l_busy, r_busy, l_we_out, r_we_out, l_stale, r_stale;

  int checks   = 0;
  int failures = 0;

  port_contention_arbiter #(
    .ADDR_W(AW), .LEFT_WINS(1'b1), .SETTLE_CYCLES(SETTLE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy(l_busy), .r_busy(r_busy),
    .l_we_out(l_we_out), .r_we_out(r_we_out),
    .l_stale(l_stale), .r_stale(r_stale)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drive all port inputs just after a falling edge, then settle 1 ns.
  task automatic drive(bit le, bit lw, int la, bit re, bit rw, int ra,
                       bit lb = 1'b0, bit rb = 1'b0);
    @(negedge clk);
    l_en = le; l_we = lw; l_addr = AW'(la);
    r_en = re; r_we = rw; r_addr = AW'(ra);
    l_busy_in = lb; r_busy_in = rb;
    #1;
  endtask

  task automatic idle();
    for (int i = 0; i < SETTLE + 2; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_no_match();
    master_mode = 1'b1;
    drive(1, 1, 5, 1, 1, 6);
    chk("R1", "busy diff addr", {l_busy, r_busy}, 2'b00);
    chk("R1", "writes diff addr", {l_we_out, r_we_out}, 2'b11);
    drive(1, 1, 5, 0, 1, 5);
    chk("R1", "busy one disabled", {l_busy, r_busy}, 2'b00);
    chk("R1", "left write one disabled", l_we_out, 1);
  endtask

  task automatic t_enable_first();
    idle();
    drive(1, 1, 'h40, 0, 0, 0);
    drive(1, 1, 'h40, 1, 1, 'h40);
    chk("R2", "right late enable busy", {l_busy, r_busy}, 2'b01);
    chk("R7", "write gating", {l_we_out, r_we_out}, 2'b10);
    drive(1, 1, 'h40, 1, 0, 'h40);
    chk("R7", "stale on busy read", {l_stale, r_stale}, 2'b01);
    idle();
    drive(0, 0, 0, 1, 0, 'h41);
    drive(1, 0, 'h41, 1, 0, 'h41);
    chk("R2", "left late enable busy", {l_busy, r_busy}, 2'b10);
    chk("R7", "stale left read", {l_stale, r_stale}, 2'b10);
  endtask

  task automatic t_addr_move();
    idle();
    drive(1, 0, 'h10, 1, 0, 'h11);
    drive(1, 0, 'h10, 1, 0, 'h11);
    drive(1, 0, 'h10, 1, 0, 'h10);
    chk("R3", "right moves onto left", {l_busy, r_busy}, 2'b01);
    drive(1, 0, 'h20, 1, 0, 'h10);
    chk("R4", "release on divergence", {l_busy, r_busy}, 2'b00);
    drive(1, 1, 'h10, 1, 0, 'h10);
    chk("R3", "left moves onto right", {l_busy, r_busy}, 2'b10);
    chk("R7", "left write masked", l_we_out, 0);
    drive(1, 1, 'h10, 0, 0, 'h10);
    chk("R4", "release on enable drop", {l_busy, r_busy}, 2'b00);
    chk("R4", "left write after release", l_we_out, 1);
  endtask

  task automatic t_hold();
    idle();
    drive(1, 1, 7, 0, 0, 0);
    drive(1, 1, 7, 1, 1, 7);
    for (int i = 0; i < 4; i++) begin
      drive(1, 1'(i % 2), 7, 1, 1'((i + 1) % 2), 7);
      chk("R6", "winner kept", {l_busy, r_busy}, 2'b01);
    end
  endtask

  task automatic t_simultaneous();
    logic [1:0] first;
    idle();
    drive(1, 1, 9, 1, 1, 9);
    first = {l_busy, r_busy};
    chk("R5", "one busy on tie", 32'(l_busy) + 32'(r_busy), 1);
    chk("R5", "one write on tie", 32'(l_we_out) + 32'(r_we_out), 1);
    drive(1, 1, 9, 1, 1, 9);
    chk("R6", "tie outcome held", {l_busy, r_busy}, first);
  endtask

  task automatic t_master_ignores();
    idle();
    master_mode = 1'b1;
    drive(1, 1, 3, 1, 1, 4, 1, 1);
    chk("R8", "master ignores busy inputs", {l_busy, r_busy}, 2'b00);
    chk("R8", "master writes pass", {l_we_out, r_we_out}, 2'b11);
  endtask

  task automatic t_slave_follow();
    idle();
    master_mode = 1'b0;
    drive(1, 0, 3, 1, 0, 3, 1, 0);
    chk("R8", "slave busy follows input", {l_busy, r_busy}, 2'b10);
    chk("R8", "slave stale on imported busy", {l_stale, r_stale}, 2'b10);
    drive(1, 0, 3, 1, 0, 3, 0, 1);
    chk("R8", "slave busy swaps", {l_busy, r_busy}, 2'b01);
  endtask

  task automatic t_settle();
    idle();
    master_mode = 1'b0;
    for (int c = 0; c <= SETTLE + 1; c++) begin
      drive(1, 1, 'h55, 0, 0, 0);
      chk("R9", $sformatf("new access cycle %0d", c), l_we_out, (c == SETTLE + 1));
    end
    drive(1, 1, 'h55, 0, 0, 0, 1, 0);
    chk("R10", "blocked while busy in", l_we_out, 0);
    for (int c = 0; c <= SETTLE; c++) begin
      drive(1, 1, 'h55, 0, 0, 0);
      chk("R10", $sformatf("after busy drop cycle %0d", c), l_we_out, (c == SETTLE));
    end
  endtask

  initial begin
    #2000000;
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_mode = 1'b1;
    l_en = 0; l_we = 0; l_addr = '0; r_en = 0; r_we = 0; r_addr = '0;
    l_busy_in = 0; r_busy_in = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "reset outputs",
        {l_busy, r_busy, l_we_out, r_we_out, l_stale, r_stale}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    t_no_match();
    t_enable_first();
    t_addr_move();
    t_hold();
    t_simultaneous();
    t_master_ignores();
    t_slave_follow();
    t_settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule